// File: doc/BRIEF.md
# Dual-Rail Undervoltage/Overvoltage Window Supervisor

This block is the clocked decision logic behind a window monitor that watches a set of supply rails (two by default). Each rail brings in two comparator results from outside: one high while the rail sits above its low trip point, the other high while it sits below its high trip point. For each rail the block reports a low-limit status, a high-limit status and a power-good flag that is the AND of the two.

Both comparator inputs pass through a two-flop synchroniser and a glitch filter timed in microsecond ticks. The two limits are handled differently. The high-limit status is considered safe from the start and follows its filtered input at once. The low-limit status starts cleared and sets only after the rail has stayed above its low trip point for a long qualification time. An enable input switches monitoring off and holds every output low. When it is raised again, monitoring starts over from the initial state.

All time constants are parameters counted in microsecond ticks. A free-running prescaler divides the system clock to make the ticks.

Top module: `window_supervisor`

## Requirements
- R1: While reset is held, all outputs are low. Once reset is released with enable high and both inputs of a rail satisfied, that rail's high-limit status is high within 4 clock cycles, and its low-limit status and power-good are still low.
- R2: A rail's low-limit status sets only after its low-limit input has been high without a break for QUAL_US ticks. It is still low 15 ticks after the input rises (QUAL_US = 20), and it is high 35 ticks after the input rises.
- R3: A rail's power-good is high only while both its low-limit status and its high-limit status are high.
- R4: If a rail's low-limit input drops and stays low for more than FILT_US ticks, that rail's low-limit status and power-good go low.
- R5: If a rail's high-limit input drops and stays low for more than FILT_US ticks, that rail's high-limit status and power-good go low.
- R6: A drop on either input that lasts fewer than FILT_US-1 ticks changes no output.
- R7: While enable is low, every status and power-good output is low. After enable returns high, the high-limit status comes back promptly, and the low-limit status goes through a full qualification again.
- R8: Once a high-limit violation clears and stays cleared past the filter time, the high-limit status returns within FILT_US+2 ticks, with no long qualification.
- R9: Once a low-limit violation clears, the qualification count restarts from zero, and the low-limit status stays low for the full QUAL_US ticks.
- R10: The rails are independent: a fault on one rail leaves the outputs of every other rail unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Asynchronous monitoring enable, high = active |
| uv_ok_raw | input | NCH | Per rail: rail is above its low trip point |
| ov_ok_raw | input | NCH | Per rail: rail is below its high trip point |
| uv_status | output | NCH | Per rail: low limit met and qualified |
| ov_status | output | NCH | Per rail: high limit met |
| pgood | output | NCH | Per rail: rail is inside its window |

## Verification
The bench builds the block with CLK_PER_US = 2, FILT_US = 4 and QUAL_US = 20. With these values a filter decision takes about eight clocks and a qualification about forty, so the short pulses that the filter should reject, the long faults that it should pass and a complete requalification all fit into a few hundred cycles. Every check is placed several ticks clear of a timing boundary. As a result, the one-tick jitter of the free-running prescaler cannot move a result across a sample point.

// File: rtl/window_supervisor.sv
module window_supervisor #(
  parameter int NCH        = 2,
  parameter int CLK_PER_US = 125,
  parameter int FILT_US    = 30,
  parameter int QUAL_US    = 160000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [NCH-1:0] uv_ok_raw,
  input  logic [NCH-1:0] ov_ok_raw,
  output logic [NCH-1:0] uv_status,
  output logic [NCH-1:0] ov_status,
  output logic [NCH-1:0] pgood
);

  localparam int SW = 2*NCH + 1;
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int FW = $clog2(FILT_US + 1);
  localparam int QW = $clog2(QUAL_US + 1);
  localparam logic [SW-1:0] SY_INIT = {1'b0, {NCH{1'b1}}, {NCH{1'b0}}};

  logic [SW-1:0]  sy1, sy2;
  logic [NCH-1:0] uv_s, ov_s, uv_f, ov_f;
  logic           en_s;
  logic [PW-1:0]  pre;
  logic           tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= SY_INIT;
      sy2 <= SY_INIT;
    end else begin
      sy1 <= {enable, ov_ok_raw, uv_ok_raw};
      sy2 <= sy1;
    end
  end

  assign en_s = sy2[SW-1];
  assign ov_s = sy2[2*NCH-1:NCH];
  assign uv_s = sy2[NCH-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || tick) pre <= '0;
    else                pre <= pre + 1'b1;
  end

  assign tick = (pre == PW'(CLK_PER_US - 1));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [FW-1:0] ucnt, ocnt;
    logic [QW-1:0] qcnt;
    logic          uf, of, us, os;

    always_ff @(posedge clk) begin
      if (!rst_n || !en_s) begin
        uf   <= 1'b0;
        ucnt <= '0;
      end else if (uv_s[i] == uf) begin
        ucnt <= '0;
      end else if (tick) begin
        if (ucnt == FW'(FILT_US - 1)) begin
          uf   <= uv_s[i];
          ucnt <= '0;
        end else begin
          ucnt <= ucnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !en_s) begin
        of   <= 1'b1;
        ocnt <= '0;
      end else if (ov_s[i] == of) begin
        ocnt <= '0;
      end else if (tick) begin
        if (ocnt == FW'(FILT_US - 1)) begin
          of   <= ov_s[i];
          ocnt <= '0;
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !uf)                        qcnt <= '0;
      else if (tick && qcnt != QW'(QUAL_US))    qcnt <= qcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        us <= 1'b0;
        os <= 1'b0;
      end else begin
        us <= en_s && uf && (qcnt == QW'(QUAL_US));
        os <= en_s && of;
      end
    end

    assign uv_f[i]      = uf;
    assign ov_f[i]      = of;
    assign uv_status[i] = us;
    assign ov_status[i] = os;
  end

  assign pgood = uv_status & ov_status;

endmodule

// File: rtl/window_supervisor_chk.sv
module window_supervisor_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_s,
  input logic [NCH-1:0] uv_f,
  input logic [NCH-1:0] ov_f,
  input logic [NCH-1:0] uv_status,
  input logic [NCH-1:0] ov_status,
  input logic [NCH-1:0] pgood
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R2
    uv_needs_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_status[i]) |-> $past(uv_f[i]));
    // R3
    pgood_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgood[i] |-> ($past(uv_f[i]) && $past(ov_f[i])));
    // R4
    uv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(uv_f[i]) |=> (!uv_status[i] && !pgood[i]));
    // R5
    ov_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ov_f[i]) |=> (!ov_status[i] && !pgood[i]));
    // R8
    ov_fast_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && ov_f[i]) |=> ov_status[i]);
    // R9
    uv_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_f[i]) |-> !uv_status[i]);
  end

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (uv_status == '0 && ov_status == '0 && pgood == '0));

endmodule

bind window_supervisor window_supervisor_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .uv_f(uv_f), .ov_f(ov_f),
  .uv_status(uv_status), .ov_status(ov_status), .pgood(pgood)
);

// File: tb/window_supervisor_tb_top.sv
module window_supervisor_tb_top;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic [NCH-1:0] uv_ok_raw = '0;
  logic [NCH-1:0] ov_ok_raw = '1;
  logic [NCH-1:0] uv_status, ov_status, pgood;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  window_supervisor #(.NCH(NCH), .CLK_PER_US(2), .FILT_US(4), .QUAL_US(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .uv_ok_raw(uv_ok_raw), .ov_ok_raw(ov_ok_raw),
    .uv_status(uv_status), .ov_status(ov_status), .pgood(pgood)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
    end
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 uv in reset", uv_status, 2'b00);
    chk("R1 ov in reset", ov_status, 2'b00);
    chk("R1 pg in reset", pgood, 2'b00);
    @(negedge clk) rst_n = 1'b1;
    cyc(5);
    chk("R1 ov after reset", ov_status, 2'b11);
    chk("R1 uv after reset", uv_status, 2'b00);
    chk("R1 pg after reset", pgood, 2'b00);
  endtask

  task automatic t_qual();
    @(negedge clk) uv_ok_raw = 2'b11;
    cyc(30);
    chk("R2 uv early", uv_status, 2'b00);
    chk("R3 pg early", pgood, 2'b00);
    cyc(40);
    chk("R2 uv qualified", uv_status, 2'b11);
    chk("R3 pg in window", pgood, 2'b11);
  endtask

  task automatic t_glitch();
    logic [NCH-1:0] seen_uv = '1, seen_ov = '1, seen_pg = '1;
    @(negedge clk);
    uv_ok_raw[0] = 1'b0;
    ov_ok_raw[1] = 1'b0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (k == 3) begin
        uv_ok_raw[0] = 1'b1;
        ov_ok_raw[1] = 1'b1;
      end
      #1;
      seen_uv &= uv_status;
      seen_ov &= ov_status;
      seen_pg &= pgood;
    end
    chk("R6 uv steady", seen_uv, 2'b11);
    chk("R6 ov steady", seen_ov, 2'b11);
    chk("R6 pg steady", seen_pg, 2'b11);
  endtask

  task automatic t_ov_fault();
    @(negedge clk) ov_ok_raw[0] = 1'b0;
    cyc(16);
    chk("R5 ov fault", ov_status, 2'b10);
    chk("R5 pg fault", pgood, 2'b10);
    chk("R10 uv untouched", uv_status, 2'b11);
    @(negedge clk) ov_ok_raw[0] = 1'b1;
    cyc(16);
    chk("R8 ov back", ov_status, 2'b11);
    chk("R8 pg back", pgood, 2'b11);
  endtask

  task automatic t_uv_fault();
    @(negedge clk) uv_ok_raw[1] = 1'b0;
    cyc(16);
    chk("R4 uv fault", uv_status, 2'b01);
    chk("R4 pg fault", pgood, 2'b01);
    chk("R10 ov untouched", ov_status, 2'b11);
    @(negedge clk) uv_ok_raw[1] = 1'b1;
    cyc(30);
    chk("R9 still requalifying", uv_status, 2'b01);
    cyc(40);
    chk("R9 requalified", uv_status, 2'b11);
    chk("R9 pg back", pgood, 2'b11);
  endtask

  task automatic t_enable();
    @(negedge clk) enable = 1'b0;
    cyc(5);
    chk("R7 uv off", uv_status, 2'b00);
    chk("R7 ov off", ov_status, 2'b00);
    chk("R7 pg off", pgood, 2'b00);
    @(negedge clk) enable = 1'b1;
    cyc(5);
    chk("R7 ov on", ov_status, 2'b11);
    chk("R7 uv restart", uv_status, 2'b00);
    cyc(70);
    chk("R7 uv requalified", uv_status, 2'b11);
    chk("R7 pg requalified", pgood, 2'b11);
  endtask

  initial begin
    t_reset();
    t_qual();
    t_glitch();
    t_ov_fault();
    t_uv_fault();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule